// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit linear address into a physical address. It reads a two-level translation table kept in ordinary memory. A requester hands over one address together with an access kind (read, write or instruction fetch). The walker then reads table words through a simple request/response memory port, one word per handshake. It ends each walk with a single-cycle result: either the physical address, or a two-bit fault code. The table root is held in a register that software writes through a small write port.

An upper-level entry can point to a lower-level table. It can also map a large region by itself, in which case the walk ends after a single memory read. A successful result also carries three flags. Two say that the final entry's referenced bit or modified bit still needs setting in memory. The third is the entry's cache-inhibit bit. The walker itself never writes memory, and it holds only one walk at a time.

Top module: `pt_walker`

## Requirements
- R1: After reset `req_ready` is 1, and `mem_req_valid` and `res_valid` are 0.
- R2: Every memory read is word aligned. The first read of a walk is at `{root[31:12], la[31:22], 2'b00}`, where `root` is the table-root register and `la` is the linear address.
- R3: When the upper entry is present and bit 7 is clear, the second read is at `{upper[31:12], la[21:12], 2'b00}`. A successful result then gives `{leaf[31:12], la[11:0]}`.
- R4: When the upper entry is present and its bit 7 is set, the walk makes exactly one read. It returns `{upper[31:22], la[21:0]}` with `res_large` set to 1.
- R5: An entry at either level whose bit 0 (present) is clear ends the walk with fault code 2'b01. No further memory read follows.
- R6: Access codes are 00 read, 01 write, 10 fetch and 11 reserved. On the final entry, a write needs bit 1 set and a fetch needs bit 2 set. A read is always allowed. The reserved code is never allowed. A refused access gives fault code 2'b10.
- R7: On success, `res_set_ref` is 1 when bit 3 of the final entry is clear, and `res_set_mod` is 1 for a write when bit 4 is clear. On any fault, `res_paddr`, `res_large` and all three flags are 0.
- R8: On success, `res_nocache` copies bit 5 of the final entry.
- R9: From the cycle after a request is taken until the result cycle, `req_ready` stays 0. A memory read that is not yet accepted keeps its valid and its address unchanged.
- R10: A write to the root register with `root_we` is used by walks accepted in later cycles. A walk accepted in the same cycle as the write still uses the old root.
- R11: `res_valid` is a one-cycle pulse carrying fault code 2'b00 on success. Code 2'b11 never appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| root_we | input | 1 | Write strobe for the table-root register |
| root_wdata | input | 32 | New table-root value |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle and able to take a request |
| req_addr | input | 32 | Linear address to translate |
| req_acc | input | 2 | Access kind: 00 read, 01 write, 10 fetch, 11 reserved |
| mem_req_valid | output | 1 | Table read request |
| mem_req_ready | input | 1 | Memory accepts the read this cycle |
| mem_req_addr | output | 32 | Byte address of the table word |
| mem_rsp_valid | input | 1 | Read data returned this cycle |
| mem_rsp_data | input | 32 | Table entry word |
| res_valid | output | 1 | Result pulse |
| res_fault | output | 2 | 00 none, 01 not present, 10 protection |
| res_paddr | output | 32 | Physical address (0 on fault) |
| res_large | output | 1 | Result came from a large mapping |
| res_nocache | output | 1 | Final entry forbids caching |
| res_set_ref | output | 1 | Referenced bit needs setting |
| res_set_mod | output | 1 | Modified bit needs setting |

## Verification
The bench targets several mistakes. An upper entry that has both the large-map bit set and the present bit clear must fault after one read. A walker that checks the large-map bit first would instead return an address from an absent entry. A root write in the same cycle as an accepted request must not steer that walk. A walker that reads the root one cycle late would send its first read into the wrong table. The bench also stalls memory acceptance and delays responses. This exposes a request that drops early or changes address, as well as a second read issued after a fault. Write and fetch are run against every permission pattern, and the reserved code is tried too. A permission check on the wrong bit, or a modified flag that is raised for reads, shows up as a wrong fault code or a stray flag.

// File: rtl/pt_walker_pkg.sv
package pt_walker_pkg;

   typedef enum logic [1:0] {
      ACC_READ  = 2'b00,
      ACC_WRITE = 2'b01,
      ACC_EXEC  = 2'b10,
      ACC_RSVD  = 2'b11
   } acc_t;

   typedef enum logic [1:0] {
      FLT_NONE   = 2'b00,
      FLT_ABSENT = 2'b01,
      FLT_PROT   = 2'b10
   } flt_t;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_L1_REQ,
      ST_L1_WAIT,
      ST_L2_REQ,
      ST_L2_WAIT,
      ST_DONE
   } walk_st_t;

   // entry flag positions
   localparam int unsigned PTE_V   = 0;
   localparam int unsigned PTE_W   = 1;
   localparam int unsigned PTE_X   = 2;
   localparam int unsigned PTE_REF = 3;
   localparam int unsigned PTE_MOD = 4;
   localparam int unsigned PTE_NC  = 5;
   localparam int unsigned PTE_BIG = 7;

endpackage

// File: rtl/pt_addr_gen.sv
module pt_addr_gen
   import pt_walker_pkg::*;
#(
   parameter int unsigned ADDR_W   = 32,
   parameter int unsigned OUTER_W  = 10,
   parameter int unsigned INNER_W  = 10,
   parameter int unsigned OFF_W    = 12,
   parameter bit          LARGE_EN = 1'b1
) (
   input  logic [ADDR_W-1:0] root_i,
   input  logic [ADDR_W-1:0] new_la_i,
   input  logic [ADDR_W-1:0] la_i,
   input  logic [ADDR_W-1:0] entry_i,
   output logic [ADDR_W-1:0] top_addr_o,
   output logic [ADDR_W-1:0] leaf_addr_o,
   output logic [ADDR_W-1:0] pa_small_o,
   output logic [ADDR_W-1:0] pa_large_o,
   output logic              big_o
);
   localparam int unsigned SPAN_W = INNER_W + OFF_W;
   localparam int unsigned OTBL_W = OUTER_W + 2;
   localparam int unsigned ITBL_W = INNER_W + 2;

   logic unused_bits;
   assign unused_bits = ^{root_i, new_la_i, la_i, entry_i};

   assign top_addr_o  = {root_i[ADDR_W-1:OTBL_W], new_la_i[ADDR_W-1:SPAN_W], 2'b00};
   assign leaf_addr_o = {entry_i[ADDR_W-1:ITBL_W], la_i[SPAN_W-1:OFF_W], 2'b00};
   assign pa_small_o  = {entry_i[ADDR_W-1:OFF_W], la_i[OFF_W-1:0]};

   generate
      if (LARGE_EN) begin : g_large
         assign big_o      = entry_i[PTE_BIG];
         assign pa_large_o = {entry_i[ADDR_W-1:SPAN_W], la_i[SPAN_W-1:0]};
      end else begin : g_small_only
         assign big_o      = 1'b0;
         assign pa_large_o = '0;
      end
   endgenerate

endmodule

// File: rtl/pt_leaf_check.sv
module pt_leaf_check
   import pt_walker_pkg::*;
#(
   parameter int unsigned ADDR_W = 32
) (
   input  logic [ADDR_W-1:0] entry_i,
   input  acc_t              acc_i,
   output flt_t              fault_o,
   output logic              set_ref_o,
   output logic              set_mod_o,
   output logic              nocache_o
);
   logic allowed;
   logic ok;
   logic unused_bits;

   assign unused_bits = ^entry_i;

   always_comb begin
      unique case (acc_i)
         ACC_READ:  allowed = 1'b1;
         ACC_WRITE: allowed = entry_i[PTE_W];
         ACC_EXEC:  allowed = entry_i[PTE_X];
         default:   allowed = 1'b0;
      endcase
   end

   always_comb begin
      if (!entry_i[PTE_V])  fault_o = FLT_ABSENT;
      else if (!allowed)    fault_o = FLT_PROT;
      else                  fault_o = FLT_NONE;
   end

   assign ok        = (fault_o == FLT_NONE);
   assign set_ref_o = ok && !entry_i[PTE_REF];
   assign set_mod_o = ok && (acc_i == ACC_WRITE) && !entry_i[PTE_MOD];
   assign nocache_o = ok && entry_i[PTE_NC];

endmodule

// File: rtl/pt_walk_ctrl.sv
module pt_walk_ctrl
   import pt_walker_pkg::*;
#(
   parameter int unsigned ADDR_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid_i,
   input  logic [ADDR_W-1:0] req_addr_i,
   input  acc_t              req_acc_i,
   output logic              req_ready_o,
   output logic              mem_req_valid_o,
   input  logic              mem_req_ready_i,
   output logic [ADDR_W-1:0] mem_req_addr_o,
   input  logic              mem_rsp_valid_i,
   input  logic              rsp_present_i,
   input  logic              big_i,
   input  logic [ADDR_W-1:0] top_addr_i,
   input  logic [ADDR_W-1:0] leaf_addr_i,
   input  logic [ADDR_W-1:0] pa_small_i,
   input  logic [ADDR_W-1:0] pa_large_i,
   input  flt_t              fault_i,
   input  logic              set_ref_i,
   input  logic              set_mod_i,
   input  logic              nocache_i,
   output logic [ADDR_W-1:0] la_o,
   output acc_t              acc_o,
   output logic              res_valid_o,
   output logic [1:0]        res_fault_o,
   output logic [ADDR_W-1:0] res_paddr_o,
   output logic              res_large_o,
   output logic              res_nocache_o,
   output logic              res_set_ref_o,
   output logic              res_set_mod_o
);
   walk_st_t          st_q;
   logic [ADDR_W-1:0] mem_addr_q;
   logic              finish;
   logic              from_top;
   logic              ok;

   always_comb begin
      finish   = 1'b0;
      from_top = 1'b0;
      if (mem_rsp_valid_i) begin
         if (st_q == ST_L1_WAIT && (!rsp_present_i || big_i)) begin
            finish   = 1'b1;
            from_top = rsp_present_i;
         end
         if (st_q == ST_L2_WAIT) finish = 1'b1;
      end
   end

   assign ok = (fault_i == FLT_NONE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q          <= ST_IDLE;
         mem_addr_q    <= '0;
         la_o          <= '0;
         acc_o         <= ACC_READ;
         res_fault_o   <= FLT_NONE;
         res_paddr_o   <= '0;
         res_large_o   <= 1'b0;
         res_nocache_o <= 1'b0;
         res_set_ref_o <= 1'b0;
         res_set_mod_o <= 1'b0;
      end else if (finish) begin
         st_q          <= ST_DONE;
         res_fault_o   <= fault_i;
         res_paddr_o   <= !ok ? '0 : (from_top ? pa_large_i : pa_small_i);
         res_large_o   <= ok && from_top;
         res_nocache_o <= nocache_i;
         res_set_ref_o <= set_ref_i;
         res_set_mod_o <= set_mod_i;
      end else begin
         unique case (st_q)
            ST_IDLE: if (req_valid_i) begin
               la_o       <= req_addr_i;
               acc_o      <= req_acc_i;
               mem_addr_q <= top_addr_i;
               st_q       <= ST_L1_REQ;
            end
            ST_L1_REQ:  if (mem_req_ready_i) st_q <= ST_L1_WAIT;
            ST_L1_WAIT: if (mem_rsp_valid_i) begin
               mem_addr_q <= leaf_addr_i;
               st_q       <= ST_L2_REQ;
            end
            ST_L2_REQ:  if (mem_req_ready_i) st_q <= ST_L2_WAIT;
            ST_L2_WAIT: st_q <= ST_L2_WAIT;
            default:    st_q <= ST_IDLE;
         endcase
      end
   end

   assign req_ready_o     = (st_q == ST_IDLE);
   assign mem_req_valid_o = (st_q == ST_L1_REQ) || (st_q == ST_L2_REQ);
   assign mem_req_addr_o  = mem_addr_q;
   assign res_valid_o     = (st_q == ST_DONE);

endmodule

// File: rtl/pt_walker.sv
module pt_walker
   import pt_walker_pkg::*;
#(
   parameter int unsigned ADDR_W   = 32,
   parameter int unsigned OUTER_W  = 10,
   parameter int unsigned INNER_W  = 10,
   parameter int unsigned OFF_W    = 12,
   parameter bit          LARGE_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              root_we,
   input  logic [ADDR_W-1:0] root_wdata,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [1:0]        req_acc,
   output logic              mem_req_valid,
   input  logic              mem_req_ready,
   output logic [ADDR_W-1:0] mem_req_addr,
   input  logic              mem_rsp_valid,
   input  logic [ADDR_W-1:0] mem_rsp_data,
   output logic              res_valid,
   output logic [1:0]        res_fault,
   output logic [ADDR_W-1:0] res_paddr,
   output logic              res_large,
   output logic              res_nocache,
   output logic              res_set_ref,
   output logic              res_set_mod
);
   generate
      if (OUTER_W + INNER_W + OFF_W != ADDR_W) begin : g_bad_split
         $error("index and offset widths must add up to ADDR_W");
      end
      if (OFF_W <= PTE_BIG || INNER_W + 2 <= PTE_BIG || OUTER_W + 2 > ADDR_W) begin : g_bad_flags
         $error("flag bits must lie below every frame and table field");
      end
   endgenerate

   logic [ADDR_W-1:0] root_q;
   logic [ADDR_W-1:0] la_q;
   acc_t              acc_q;
   logic [ADDR_W-1:0] top_addr, leaf_addr, pa_small, pa_large;
   logic              big;
   flt_t              leaf_fault;
   logic              leaf_ref, leaf_mod, leaf_nc;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       root_q <= '0;
      else if (root_we) root_q <= root_wdata;
   end

   pt_addr_gen #(
      .ADDR_W(ADDR_W), .OUTER_W(OUTER_W), .INNER_W(INNER_W),
      .OFF_W(OFF_W), .LARGE_EN(LARGE_EN)
   ) u_addr (
      .root_i(root_q), .new_la_i(req_addr), .la_i(la_q), .entry_i(mem_rsp_data),
      .top_addr_o(top_addr), .leaf_addr_o(leaf_addr),
      .pa_small_o(pa_small), .pa_large_o(pa_large), .big_o(big)
   );

   pt_leaf_check #(.ADDR_W(ADDR_W)) u_check (
      .entry_i(mem_rsp_data), .acc_i(acc_q), .fault_o(leaf_fault),
      .set_ref_o(leaf_ref), .set_mod_o(leaf_mod), .nocache_o(leaf_nc)
   );

   pt_walk_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
      .clk(clk), .rst_n(rst_n),
      .req_valid_i(req_valid), .req_addr_i(req_addr), .req_acc_i(acc_t'(req_acc)),
      .req_ready_o(req_ready),
      .mem_req_valid_o(mem_req_valid), .mem_req_ready_i(mem_req_ready),
      .mem_req_addr_o(mem_req_addr), .mem_rsp_valid_i(mem_rsp_valid),
      .rsp_present_i(mem_rsp_data[PTE_V]), .big_i(big),
      .top_addr_i(top_addr), .leaf_addr_i(leaf_addr),
      .pa_small_i(pa_small), .pa_large_i(pa_large),
      .fault_i(leaf_fault), .set_ref_i(leaf_ref), .set_mod_i(leaf_mod), .nocache_i(leaf_nc),
      .la_o(la_q), .acc_o(acc_q),
      .res_valid_o(res_valid), .res_fault_o(res_fault), .res_paddr_o(res_paddr),
      .res_large_o(res_large), .res_nocache_o(res_nocache),
      .res_set_ref_o(res_set_ref), .res_set_mod_o(res_set_mod)
   );

endmodule

// File: rtl/pt_walker_chk.sv
module pt_walker_chk #(
   parameter int unsigned ADDR_W  = 32,
   parameter int unsigned INNER_W = 10,
   parameter int unsigned OFF_W   = 12
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic              req_ready,
   input logic [ADDR_W-1:0] req_addr,
   input logic [1:0]        req_acc,
   input logic              mem_req_valid,
   input logic              mem_req_ready,
   input logic [ADDR_W-1:0] mem_req_addr,
   input logic              res_valid,
   input logic [1:0]        res_fault,
   input logic [ADDR_W-1:0] res_paddr,
   input logic              res_large,
   input logic              res_set_ref,
   input logic              res_set_mod
);
   localparam logic [ADDR_W-1:0] SMALL_MASK = ADDR_W'((64'd1 << OFF_W) - 64'd1);
   localparam logic [ADDR_W-1:0] LARGE_MASK = ADDR_W'((64'd1 << (INNER_W + OFF_W)) - 64'd1);

   logic [ADDR_W-1:0] la_seen;
   logic [1:0]        acc_seen;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         la_seen  <= '0;
         acc_seen <= 2'b00;
      end else if (req_valid && req_ready) begin
         la_seen  <= req_addr;
         acc_seen <= req_acc;
      end
   end

   AST_ONE_WALK: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && req_ready |=> !req_ready);  // R9
   AST_MEMREQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));  // R9
   AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |-> !mem_req_valid && !req_ready);  // R9
   AST_WORD_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_valid |-> mem_req_addr[1:0] == 2'b00);  // R2
   AST_RES_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |=> !res_valid);  // R11
   AST_FAULT_CODE: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |-> res_fault != 2'b11);  // R11
   AST_FAULT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid && res_fault != 2'b00 |-> res_paddr == '0 && !res_large && !res_set_ref && !res_set_mod);  // R7
   AST_MOD_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid && res_set_mod |-> acc_seen == 2'b01);  // R7
   AST_SMALL_OFFSET: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid && res_fault == 2'b00 && !res_large |-> ((res_paddr ^ la_seen) & SMALL_MASK) == '0);  // R3
   AST_LARGE_OFFSET: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid && res_large |-> ((res_paddr ^ la_seen) & LARGE_MASK) == '0);  // R4

endmodule

bind pt_walker pt_walker_chk #(.ADDR_W(ADDR_W), .INNER_W(INNER_W), .OFF_W(OFF_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
   .req_addr(req_addr), .req_acc(req_acc), .mem_req_valid(mem_req_valid),
   .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr), .res_valid(res_valid),
   .res_fault(res_fault), .res_paddr(res_paddr), .res_large(res_large),
   .res_set_ref(res_set_ref), .res_set_mod(res_set_mod)
);

// File: tb/sim_pt_walker.sv
`timescale 1ns/1ps
module sim_pt_walker;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        root_we = 1'b0;
   logic [31:0] root_wdata = '0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [31:0] req_addr = '0;
   logic [1:0]  req_acc = 2'b00;
   logic        mem_req_valid;
   logic        mem_req_ready = 1'b1;
   logic [31:0] mem_req_addr;
   logic        mem_rsp_valid = 1'b0;
   logic [31:0] mem_rsp_data = '0;
   logic        res_valid;
   logic [1:0]  res_fault;
   logic [31:0] res_paddr;
   logic        res_large, res_nocache, res_set_ref, res_set_mod;

   always #2.5 clk = ~clk;

   pt_walker u0 (.*);

   int          n_checks = 0;
   int          n_errors = 0;
   int          cyc = 0;
   logic [31:0] mem [logic [31:0]];
   logic [31:0] exp_q [$];
   logic [31:0] model_root = '0;
   bit          model_busy = 0;
   bit          stall = 0;
   int          lat = 0;
   logic        hs = 1'b0;
   logic [31:0] hs_addr = '0;
   bit          pend = 0;
   int          wait_n = 0;
   logic [31:0] raddr = '0;

   task automatic chk(input string req, input string what, input logic [31:0] got, input logic [31:0] exp);
      n_checks++;
      if (got !== exp) begin
         n_errors++;
         $display("FAIL %s %s: actual %h expected %h", req, what, got, exp);
      end
   endtask

   function automatic logic [31:0] rd(input logic [31:0] a);
      return mem.exists(a) ? mem[a] : 32'h0;
   endfunction

   always @(posedge clk) begin
      cyc <= cyc + 1;
      hs <= mem_req_valid && mem_req_ready;
      hs_addr <= mem_req_addr;
      if (cyc > 100000) begin
         n_errors++;
         $display("FAIL R9 watchdog: actual %0d cycles expected fewer than 100000", cyc);
         $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
         $finish;
      end
   end

   // memory responder and per-cycle monitor, all away from the active edge
   always @(negedge clk) begin
      mem_rsp_valid = 1'b0;
      if (rst_n && hs) begin
         if (exp_q.size() == 0) chk("R5", "unexpected table read", hs_addr, 32'hxxxx_xxxx);
         else chk("R2", "table read address", hs_addr, exp_q.pop_front());
         pend = 1; wait_n = lat; raddr = hs_addr;
      end
      if (pend) begin
         if (wait_n == 0) begin
            mem_rsp_valid = 1'b1; mem_rsp_data = rd(raddr); pend = 0;
         end else wait_n--;
      end
      mem_req_ready = stall ? ((cyc % 3) == 2) : 1'b1;
      if (model_busy) chk("R9", "req_ready while busy", {31'd0, req_ready}, 32'd0);
   end

   task automatic walk(input logic [31:0] la, input logic [1:0] acc, input bit wr_root,
                       input logic [31:0] nroot, input string tag);
      logic [31:0] e1, e2, leaf, a1, a2, pa;
      logic [1:0]  flt;
      bit          big, ok, allow;
      a1 = {model_root[31:12], la[31:22], 2'b00};
      e1 = rd(a1);
      exp_q.push_back(a1);
      big = 0; leaf = 32'h0; pa = 32'h0;
      if (!e1[0]) flt = 2'b01;
      else if (e1[7]) begin
         big = 1; leaf = e1; flt = 2'b00;
         pa = (e1 & 32'hFFC0_0000) | (la & 32'h003F_FFFF);
      end else begin
         a2 = {e1[31:12], la[21:12], 2'b00};
         exp_q.push_back(a2);
         e2 = rd(a2); leaf = e2;
         flt = e2[0] ? 2'b00 : 2'b01;
         pa = (e2 & 32'hFFFF_F000) | (la & 32'h0000_0FFF);
      end
      if (flt == 2'b00) begin
         case (acc)
            2'b00: allow = 1;
            2'b01: allow = leaf[1];
            2'b10: allow = leaf[2];
            default: allow = 0;
         endcase
         if (!allow) flt = 2'b10;
      end
      ok = (flt == 2'b00);
      @(negedge clk);
      while (!req_ready) @(negedge clk);
      req_valid = 1'b1; req_addr = la; req_acc = acc;
      if (wr_root) begin root_we = 1'b1; root_wdata = nroot; end
      @(negedge clk);
      req_valid = 1'b0; root_we = 1'b0; model_busy = 1;
      if (wr_root) model_root = nroot;
      while (!res_valid) @(negedge clk);
      model_busy = 0;
      chk(tag, "R5 R6 fault code", {30'd0, res_fault}, {30'd0, flt});
      chk(tag, "R3 R4 physical address", res_paddr, ok ? pa : 32'h0);
      chk(tag, "R4 large flag", {31'd0, res_large}, {31'd0, ok && big});
      chk(tag, "R8 nocache flag", {31'd0, res_nocache}, {31'd0, ok && leaf[5]});
      chk(tag, "R7 referenced flag", {31'd0, res_set_ref}, {31'd0, ok && !leaf[3]});
      chk(tag, "R7 modified flag", {31'd0, res_set_mod}, {31'd0, ok && acc == 2'b01 && !leaf[4]});
      chk(tag, "R5 reads left over", exp_q.size(), 32'd0);
      @(negedge clk);
      chk("R11", "result pulse length", {31'd0, res_valid}, 32'd0);
   endtask

   initial begin
      // root 0x0001_0000: upper slot 1 -> lower table at 0x0002_0000
      mem[32'h0001_0004] = 32'h0002_0001;
      for (int i = 0; i < 8; i++) begin
         logic [31:0] e;
         e = ((32'h12340 + i) << 12) | 32'h1;
         if (i % 2 == 0) e |= 32'h2;
         if (i % 3 == 0) e |= 32'h4;
         if (i % 2 == 1) e |= 32'h8;
         if (i == 4)     e |= 32'h10;
         if (i == 5)     e |= 32'h20;
         if (i == 7)     e = 32'h0;
         mem[32'h0002_0000 + 4 * i] = e;
      end
      mem[32'h0001_0008] = 32'h0C00_008D;   // large, present, fetch, referenced
      mem[32'h0001_0018] = 32'h0300_0080;   // large bit set but absent
      mem[32'h0005_0004] = 32'h4000_0089;   // second root: large mapping

      repeat (3) @(negedge clk);
      chk("R1", "req_ready in reset", {31'd0, req_ready}, 32'd1);
      chk("R1", "mem_req_valid in reset", {31'd0, mem_req_valid}, 32'd0);
      chk("R1", "res_valid in reset", {31'd0, res_valid}, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1", "req_ready after reset", {31'd0, req_ready}, 32'd1);

      root_we = 1'b1; root_wdata = 32'h0001_0000;
      @(negedge clk);
      root_we = 1'b0; model_root = 32'h0001_0000;

      for (int i = 0; i < 8; i++) walk((32'd1 << 22) | (i << 12) | 32'h0ABC + i, 2'b00, 0, 0, "R3");
      for (int i = 0; i < 8; i++) walk((32'd1 << 22) | (i << 12) | 32'h0123, 2'b01, 0, 0, "R7");
      for (int i = 0; i < 8; i++) walk((32'd1 << 22) | (i << 12) | 32'h0F00, 2'b10, 0, 0, "R6");
      walk((32'd1 << 22) | (32'd2 << 12), 2'b11, 0, 0, "R6");
      walk((32'd2 << 22) | 32'h0009_ABCD, 2'b10, 0, 0, "R4");
      walk((32'd2 << 22) | 32'h003F_FFFC, 2'b00, 0, 0, "R4");
      walk((32'd2 << 22) | 32'h0000_0010, 2'b01, 0, 0, "R6");
      walk((32'd5 << 22) | 32'h0000_1234, 2'b00, 0, 0, "R5");
      walk((32'd6 << 22) | 32'h0000_1234, 2'b00, 0, 0, "R5");
      walk((32'd1 << 22) | (32'd5 << 12) | 32'h0044, 2'b00, 0, 0, "R8");

      stall = 1; lat = 3;
      walk((32'd1 << 22) | (32'd4 << 12) | 32'h0777, 2'b01, 0, 0, "R9");
      walk((32'd2 << 22) | 32'h0012_3456, 2'b10, 0, 0, "R9");
      walk((32'd1 << 22) | (32'd7 << 12), 2'b00, 0, 0, "R9");
      stall = 0; lat = 1;

      // root write in the acceptance cycle: this walk keeps the old root
      walk((32'd1 << 22) | (32'd2 << 12) | 32'h0555, 2'b00, 1, 32'h0005_0000, "R10");
      walk((32'd1 << 22) | (32'd2 << 12) | 32'h0555, 2'b00, 0, 0, "R10");
      lat = 0;
      walk((32'd1 << 22) | 32'h002A_BCDE, 2'b01, 0, 0, "R11");

      repeat (4) @(negedge clk);
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
   end
endmodule